// File: doc/BRIEF.md
# Serial Input Interrupt Detector

The block sits behind a serial GPIO shifter and looks at the input bits that the shifter captures at the end of every burst. Those bits come as several bit-index words, each holding one bit per port. Every pin (port p, bit index b) has a pending flag. The flag is set on a burst load according to that pin's trigger type. The types are level (with polarity), both edges, falling edge only and rising edge only. Edges are taken between the value captured in this burst and the value captured in the previous burst.

Software reaches the block through a small register interface. Its addresses are split into a 3-bit group field and an index field. It holds per-word enable masks, two trigger words per bit index, polarity words, write-one-to-clear acknowledge words, read-only identity words (pending AND enabled) and a master enable. One interrupt line is the OR of all identity bits, gated by the master enable.

Top module: `sio_irq_detect`

## Requirements
- R1: After reset all enable, trigger, polarity and master bits are 0, no pin is pending, every identity word and the configuration word read 0, and `irq` is 0.
- R2: A pin with trigger type 1 (both edges) becomes pending on a burst load whose captured value differs from its value in the previous load. The value before the first load after reset is 0.
- R3: A pin with trigger type 3 becomes pending only on a 0 to 1 change between consecutive loads.
- R4: A pin with trigger type 2 becomes pending only on a 1 to 0 change between consecutive loads.
- R5: A pin with trigger type 0 is level sensitive. Polarity 0 is active high and polarity 1 is active low. Its flag is set on every load that captures the active level, including repeated loads of the same value.
- R6: The 2-bit trigger type of pin (p, b) takes its low bit from trigger word b (index b) and its high bit from trigger word NUM_BITS+b, both at bit position p. Captured input bit b*NUM_PORTS+p of `burst_data` belongs to that pin. Trigger words read back as written.
- R7: Writing a word to acknowledge index b clears the pending flag at each position written as 1 and leaves positions written as 0 unchanged. If a load sets a flag in the same cycle as its acknowledge, the flag stays set.
- R8: Identity word b reads pending AND enable word b. A pin becomes pending whatever its enable, so a later enable exposes it at once.
- R9: `irq` is 1 exactly when bit 0 of the configuration word (master enable) is 1 and at least one identity bit is 1.
- R10: Pending flags are set and the previous-burst value is updated only in cycles with `burst_load` high. Changes on `burst_data` in other cycles have no effect.
- R11: A pending flag, its identity bit and `irq` change on the clock edge that samples the load or the acknowledge write. None of them changes earlier.

Register map: group field codes are 0 configuration, 1 enable, 2 trigger, 3 polarity, 4 acknowledge (reads 0), and 5 identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| burst_load | input | 1 | One-cycle strobe: `burst_data` holds a newly captured burst |
| burst_data | input | NUM_BITS*NUM_PORTS | Captured inputs, bit b*NUM_PORTS+p is pin (p, b) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3+IDXW | {group, index} register address |
| reg_wdata | input | NUM_PORTS | Write data, one bit per port |
| reg_rdata | output | NUM_PORTS | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Every result is due one clock edge after its stimulus. A load or an acknowledge write is registered at the sampling edge, and identity, read data and `irq` follow from those registers with no further delay. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It checks results on that second falling edge, so exactly one rising edge has passed. For the timing requirement it also samples `irq` between raising the load strobe and the rising edge, to confirm nothing changes early. Reads set the address away from any edge and sample after a short settle, because read data is combinational.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  typedef enum logic [2:0] {
    GRP_CFG   = 3'd0,
    GRP_ENA   = 3'd1,
    GRP_TRIG  = 3'd2,
    GRP_POL   = 3'd3,
    GRP_ACK   = 3'd4,
    GRP_IDENT = 3'd5
  } reg_grp_e;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_ANY   = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_RISE  = 2'd3
  } trig_e;

  // Decide whether one pin fires for a given burst sample.
  function automatic logic pin_fires(trig_e kind, logic cur, logic prev, logic low_act);
    logic hit;
    case (kind)
      TRIG_LEVEL: hit = cur ^ low_act;
      TRIG_ANY:   hit = cur ^ prev;
      TRIG_FALL:  hit = prev & ~cur;
      TRIG_RISE:  hit = cur & ~prev;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/sio_irq_regs.sv
module sio_irq_regs
  import sio_irq_pkg::*;
#(
  parameter int NB   = 4,
  parameter int NP   = 32,
  parameter int IDXW = 3,
  parameter int AW   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [NP-1:0]    wdata,
  input  logic [NB*NP-1:0] ident,
  output logic             master_en,
  output logic [NB*NP-1:0] ena,
  output logic [NB*NP-1:0] tlo,
  output logic [NB*NP-1:0] thi,
  output logic [NB*NP-1:0] pol,
  output logic [NB*NP-1:0] ack,
  output logic [NP-1:0]    rdata
);

  reg_grp_e            grp;
  logic [IDXW-1:0]     idx;
  logic [NB-1:0][NP-1:0] ena_q, tlo_q, thi_q, pol_q, ack_w, ident_w;
  logic [NB-1:0]       ena_we, tlo_we, thi_we, pol_we;
  logic                cfg_we;
  logic                master_q;

  assign grp     = reg_grp_e'(addr[AW-1:IDXW]);
  assign idx     = addr[IDXW-1:0];
  assign ident_w = ident;

  // write decode: one clock enable per stored word
  always_comb begin
    cfg_we = we && (grp == GRP_CFG) && (idx == '0);
    for (int b = 0; b < NB; b++) begin
      ena_we[b] = we && (grp == GRP_ENA)  && (idx == IDXW'(b));
      tlo_we[b] = we && (grp == GRP_TRIG) && (idx == IDXW'(b));
      thi_we[b] = we && (grp == GRP_TRIG) && (idx == IDXW'(NB + b));
      pol_we[b] = we && (grp == GRP_POL)  && (idx == IDXW'(b));
      ack_w[b]  = (we && (grp == GRP_ACK) && (idx == IDXW'(b))) ? wdata : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      ena_q    <= '0;
      tlo_q    <= '0;
      thi_q    <= '0;
      pol_q    <= '0;
    end else begin
      if (cfg_we) master_q <= wdata[0];
      for (int b = 0; b < NB; b++) begin
        if (ena_we[b]) ena_q[b] <= wdata;
        if (tlo_we[b]) tlo_q[b] <= wdata;
        if (thi_we[b]) thi_q[b] <= wdata;
        if (pol_we[b]) pol_q[b] <= wdata;
      end
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (grp == GRP_CFG && idx == '0) rdata = NP'(master_q);
    for (int b = 0; b < NB; b++) begin
      if (idx == IDXW'(b)) begin
        if (grp == GRP_ENA)   rdata = ena_q[b];
        if (grp == GRP_TRIG)  rdata = tlo_q[b];
        if (grp == GRP_POL)   rdata = pol_q[b];
        if (grp == GRP_IDENT) rdata = ident_w[b];
      end
      if (grp == GRP_TRIG && idx == IDXW'(NB + b)) rdata = thi_q[b];
    end
  end

  assign master_en = master_q;
  assign ena       = ena_q;
  assign tlo       = tlo_q;
  assign thi       = thi_q;
  assign pol       = pol_q;
  assign ack       = ack_w;

  AST_ACK_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_we, |ack_w, |ena_we, |pol_we})) else $error("ack decode overlap"); // R7

endmodule

// File: rtl/sio_irq_pend.sv
module sio_irq_pend
  import sio_irq_pkg::*;
#(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] din,
  input  logic [N-1:0] tlo,
  input  logic [N-1:0] thi,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);

  logic [N-1:0] prev_q, prev_d;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] fire;

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign fire[i] = load & pin_fires(trig_e'({thi[i], tlo[i]}), din[i], prev_q[i], pol[i]);
  end

  always_comb begin
    pend_d = (pend_q & ~ack) | fire;
    prev_d = load ? din : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      prev_q <= prev_d;
    end
  end

  assign pend = pend_q;

  AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((pend_q & ~$past(pend_q)) == '0)) else $error("flag set without load"); // R10
  AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(prev_q)) else $error("previous burst moved without load"); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((pend_q & $past(ack)) == '0)) else $error("ack did not clear"); // R7
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((pend_q & ~$past(pend_q) & $past(thi & tlo) & ~$past(din & ~prev_q)) == '0))
    else $error("rise pin set without rise"); // R3
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((pend_q & ~$past(pend_q) & $past(thi & ~tlo) & ~$past(~din & prev_q)) == '0))
    else $error("fall pin set without fall"); // R4

endmodule

// File: rtl/sio_irq_detect.sv
module sio_irq_detect #(
  parameter int NUM_BITS  = 4,
  parameter int NUM_PORTS = 32,
  localparam int IDXW     = $clog2(2 * NUM_BITS),
  localparam int AW       = 3 + IDXW,
  localparam int NPIN     = NUM_BITS * NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 burst_load,
  input  logic [NPIN-1:0]      burst_data,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [NUM_PORTS-1:0] reg_wdata,
  output logic [NUM_PORTS-1:0] reg_rdata,
  output logic                 irq
);

  logic [1:0]      rst_pipe;
  logic            rst_core_n;
  logic            master_en;
  logic [NPIN-1:0] ena, tlo, thi, pol, ack, pend, ident;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  sio_irq_regs #(
    .NB(NUM_BITS), .NP(NUM_PORTS), .IDXW(IDXW), .AW(AW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .ident     (ident),
    .master_en (master_en),
    .ena       (ena),
    .tlo       (tlo),
    .thi       (thi),
    .pol       (pol),
    .ack       (ack),
    .rdata     (reg_rdata)
  );

  sio_irq_pend #(.N(NPIN)) u_pend (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (burst_load),
    .din   (burst_data),
    .tlo   (tlo),
    .thi   (thi),
    .pol   (pol),
    .ack   (ack),
    .pend  (pend)
  );

  assign ident = pend & ena;
  assign irq   = master_en & (|ident);

  AST_IRQ_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> (pend != '0)) else $error("irq without pending pin"); // R9

endmodule

// File: tb/sio_irq_detect_tb.sv
module sio_irq_detect_tb;

  localparam int NB = 4;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          burst_load;
  logic [NB*NP-1:0] burst_data;
  logic          reg_we;
  logic [5:0]    reg_addr;
  logic [NP-1:0] reg_wdata;
  logic [NP-1:0] reg_rdata;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sio_irq_detect #(.NUM_BITS(NB), .NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_load(burst_load), .burst_data(burst_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [2:0] G_CFG = 3'd0, G_ENA = 3'd1, G_TRIG = 3'd2,
                         G_POL = 3'd3, G_ACK = 3'd4, G_ID = 3'd5;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] g, logic [2:0] i, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {g, i}; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] g, logic [2:0] i, output logic [31:0] v);
    reg_addr = {g, i};
    #1;
    v = reg_rdata;
  endtask

  task automatic load(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
    @(negedge clk);
    burst_load = 1'b1; burst_data = {w3, w2, w1, w0};
    @(negedge clk);
    burst_load = 1'b0;
  endtask

  task automatic chk_id(string tag, int b, logic [31:0] exp);
    logic [31:0] v;
    rd(G_ID, 3'(b), v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 32'h0);
    for (int b = 0; b < NB; b++) begin
      rd(G_ID, 3'(b), v);  chk("R1 ident", v, 32'h0);
    end
    rd(G_CFG, 3'd0, v);    chk("R1 cfg", v, 32'h0);
    rd(G_ENA, 3'd0, v);    chk("R1 enable", v, 32'h0);
    rd(G_TRIG, 3'd4, v);   chk("R1 trig", v, 32'h0);
  endtask

  task automatic t_config;
    logic [31:0] v;
    wr(G_CFG, 3'd0, 32'h1);
    wr(G_ENA, 3'd0, 32'hFFFF_FFFF);
    wr(G_TRIG, 3'd0, 32'h00FF_00FF);   // low type bits, bit index 0
    wr(G_TRIG, 3'd4, 32'h00FF_FF00);   // high type bits, bit index 0
    wr(G_POL, 3'd0, 32'hF000_0000);
    rd(G_TRIG, 3'd4, v); chk("R6 high trigger word readback", v, 32'h00FF_FF00);
    rd(G_TRIG, 3'd0, v); chk("R6 low trigger word readback", v, 32'h00FF_00FF);
    chk("R9 irq idle", 32'(irq), 32'h0);
  endtask

  task automatic t_edges;
    load(32'h0F0F_0F0F, 0, 0, 0);
    chk_id("R2 R3 R5 first burst", 0, 32'hFF0F_000F);
    chk("R9 irq set", 32'(irq), 32'h1);
    wr(G_ACK, 3'd0, 32'hFFFF_FFFF);
    chk_id("R7 ack all", 0, 32'h0);
    chk("R9 irq cleared", 32'(irq), 32'h0);
    load(32'hF0F0_F0F0, 0, 0, 0);
    chk_id("R2 R3 R4 toggle burst", 0, 32'h00F0_0FFF);
    wr(G_ACK, 3'd0, 32'h0000_000F);
    chk_id("R7 partial ack", 0, 32'h00F0_0FF0);
    load(32'hF0F0_F0F0, 0, 0, 0);
    chk_id("R2 no change", 0, 32'h00F0_0FF0);
    wr(G_ACK, 3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    load(32'h0F00_0000, 0, 0, 0);
    chk_id("R4 R5 level and falls", 0, 32'hFF00_F0F0);
    wr(G_ACK, 3'd0, 32'hFFFF_FFFF);
    load(32'h0F00_0000, 0, 0, 0);
    chk_id("R5 level repeats", 0, 32'hFF00_0000);
    @(negedge clk);
    burst_data[31:0] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk_id("R10 data without load", 0, 32'hFF00_0000);
    wr(G_ACK, 3'd0, 32'hFFFF_FFFF);
    load(32'h0F00_0000, 0, 0, 0);
    chk_id("R10 previous kept", 0, 32'hFF00_0000);
  endtask

  task automatic t_collision;
    @(negedge clk);
    burst_load = 1'b1; burst_data = {96'h0, 32'h0F00_0000};
    reg_we = 1'b1; reg_addr = {G_ACK, 3'd0}; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    burst_load = 1'b0; reg_we = 1'b0;
    chk_id("R7 set wins over ack", 0, 32'hFF00_0000);
    wr(G_ACK, 3'd0, 32'hFFFF_FFFF);
    chk("R7 irq after ack", 32'(irq), 32'h0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    burst_load = 1'b1; burst_data = {96'h0, 32'h0F00_0000};
    #1;
    chk("R11 irq before edge", 32'(irq), 32'h0);
    @(negedge clk);
    burst_load = 1'b0;
    chk("R11 irq after edge", 32'(irq), 32'h1);
    chk_id("R11 ident after edge", 0, 32'hFF00_0000);
    wr(G_ACK, 3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_split;
    wr(G_ENA, 3'd2, 32'h3);
    wr(G_TRIG, 3'd2, 32'h1);           // port 0 of bit 2: low type bit
    wr(G_TRIG, 3'd6, 32'h2);           // port 1 of bit 2: high type bit
    load(32'h0F00_0000, 0, 32'h3, 0);
    chk_id("R6 both-edge pin rises, fall pin quiet", 2, 32'h1);
    wr(G_ACK, 3'd2, 32'hFFFF_FFFF);
    load(32'h0F00_0000, 0, 32'h0, 0);
    chk_id("R6 both-edge and fall pins", 2, 32'h3);
    wr(G_ACK, 3'd2, 32'hFFFF_FFFF);
    wr(G_ACK, 3'd0, 32'hFFFF_FFFF);
    chk_id("R7 word 2 cleared", 2, 32'h0);
  endtask

  task automatic t_enable;
    load(32'h0F00_0000, 32'h80, 0, 0);
    chk_id("R8 pending hidden when disabled", 1, 32'h0);
    wr(G_ENA, 3'd1, 32'h80);
    chk_id("R8 exposed by enable", 1, 32'h80);
  endtask

  task automatic t_master;
    logic [31:0] v;
    chk("R9 irq with master", 32'(irq), 32'h1);
    wr(G_CFG, 3'd0, 32'h0);
    chk("R9 irq gated off", 32'(irq), 32'h0);
    rd(G_CFG, 3'd0, v); chk("R9 cfg readback", v, 32'h0);
    wr(G_CFG, 3'd0, 32'h1);
    chk("R9 irq gated on", 32'(irq), 32'h1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; burst_load = 1'b0; burst_data = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_config();
    t_edges();
    t_level();
    t_collision();
    t_timing();
    t_split();
    t_enable();
    t_master();
    summary();
    $finish;
  end

endmodule